// File: doc/BRIEF.md
# Bank-Selected CAM Line Cache

This block is a 4 KB unified read cache that sits between a processor with a 26-bit byte address and a simple word-wide memory port. It holds 256 lines of 16 bytes, split into four banks of 64 entries. Two address bits pick the bank, and every entry of that bank compares its tag in parallel. Instruction and data fetches use the same entries.

On a read hit the requested word comes back from the internal line store one cycle after acceptance. On a read miss the block fetches the four words of the line in ascending order, writes them into a pseudo-randomly chosen entry of the selected bank, and then answers with the requested word. A write never updates data. If it matches a resident line, that entry is invalidated. A flush input empties every bank in a single cycle.

The requester raises `req_valid` with the address and holds both until `rsp_ready` pulses for one cycle. The memory side raises `mem_req` with a word address and holds it until the memory answers with `mem_ack` and `mem_data` in the same cycle.

Top module: `cam_line_cache`

## Requirements
- R1: Address bits 3:0 select the byte within a 16-byte line. Bits 3:2 select the word. Bits 5:4 select one of four banks. Bits 25:6 form the stored tag. Lines that differ only in bits 5:4 are held independently, and lines in one bank that differ in the tag do not alias.
- R2: A read that hits returns the stored word with `rsp_ready` high exactly one cycle after acceptance, and `mem_req` stays low.
- R3: A read miss fetches exactly four words at the line-aligned address plus 0, 4, 8 and 12, in that order. `mem_req` and `mem_addr` hold steady while `mem_ack` is low.
- R4: After a miss, `rsp_ready` rises in the cycle after the fourth word is accepted, carrying the requested word.
- R5: A line becomes resident once its fill completes, so an immediate re-read of any word in it hits.
- R6: A write that matches a resident line invalidates it, so the next read of that line misses. A write that matches nothing leaves every resident line intact.
- R7: A one-cycle `flush` pulse invalidates every entry of all banks by the next cycle. A read accepted in the same cycle as the flush is treated as a miss.
- R8: The victim for a fill is drawn from a free-running 6-bit maximal-length LFSR, sampled when the miss is detected. Any of the 64 entries of the bank may be chosen, including the same entry twice in a row. Filling 65 distinct lines into one bank therefore evicts at least one of them.
- R9: A bank never holds two valid entries with the same tag.
- R10: `rsp_ready` is a single-cycle pulse. A write is acknowledged one cycle after acceptance and causes no memory traffic.
- R11: After reset, all entries are invalid, and both `rsp_ready` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every entry |
| req_valid | input | 1 | Processor request present, held until `rsp_ready` |
| req_write | input | 1 | Request is a write (invalidate-only) |
| req_addr | input | 26 | Byte address of the request |
| rsp_ready | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Word returned for a read |
| mem_req | output | 1 | Line-fill word request |
| mem_addr | output | 26 | Byte address of the fill word |
| mem_ack | input | 1 | Memory returns the requested word this cycle |
| mem_data | input | 32 | Fill word from memory |

## Verification
The bench builds the block with its default parameters: four banks of 64 entries, a 20-bit tag and four words per line. Full-size banks let the bench drive 65 distinct lines into one bank, which makes eviction certain without any knowledge of the random victim. Stalled memory acknowledgements exercise the hold behaviour of the fill port. A write followed by a re-read after each fill exposes a duplicate-tag entry at the ports, because a surviving copy would turn the expected miss into a hit.

// File: rtl/cc_cache_pkg.sv
package cc_cache_pkg;

    // Default geometry of the cache.
    localparam int unsigned CC_ADDR_W      = 26;
    localparam int unsigned CC_WORD_W      = 32;
    localparam int unsigned CC_BEAT_BITS   = 2;   // log2 words per line
    localparam int unsigned CC_BANK_BITS   = 2;   // log2 banks
    localparam int unsigned CC_WAY_BITS    = 6;   // log2 entries per bank
    localparam logic [5:0]  CC_VICTIM_TAPS = 6'b110000;  // x^6 + x^5 + 1

    // Controller phases.
    typedef enum logic [1:0] {
        CC_IDLE = 2'd0,   // waiting for a request, lookup is combinational
        CC_FILL = 2'd1,   // streaming a line in from memory
        CC_DONE = 2'd2    // response strobe cycle
    } cc_phase_e;

    // Decision taken on an accepted request.
    typedef struct packed {
        logic read_hit;
        logic read_miss;
        logic write_hit;
    } cc_decision_t;

    function automatic cc_decision_t cc_decide(input logic is_write,
                                               input logic hit);
        cc_decision_t d;
        d.read_hit  = !is_write && hit;
        d.read_miss = !is_write && !hit;
        d.write_hit = is_write && hit;
        return d;
    endfunction

endpackage

// File: rtl/cc_victim_gen.sv
module cc_victim_gen #(
    parameter int unsigned W    = 6,
    parameter logic [W-1:0] TAPS = 6'b110000
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] way_o
);
    logic [W-1:0] lfsr_q;
    logic         phase_q;
    logic         fb;

    assign fb = ^(lfsr_q & TAPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q  <= {{(W-1){1'b0}}, 1'b1};
            phase_q <= 1'b0;
        end else begin
            lfsr_q  <= {lfsr_q[W-2:0], fb};
            phase_q <= ~phase_q;
        end
    end

    // The LFSR never yields zero; a toggling phase bit inverts every other
    // state so that every entry index, zero included, is reachable.
    assign way_o = lfsr_q ^ {W{phase_q}};

endmodule

// File: rtl/cc_tag_bank.sv
module cc_tag_bank #(
    parameter int unsigned WAY_BITS = 6,
    parameter int unsigned TAG_W    = 20,
    localparam int unsigned WAYS    = 1 << WAY_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_all,
    input  logic [TAG_W-1:0]    lk_tag,
    input  logic                inv_en,
    input  logic [WAY_BITS-1:0] inv_way,
    input  logic                set_en,
    input  logic [WAY_BITS-1:0] set_way,
    input  logic [TAG_W-1:0]    set_tag,
    output logic [WAYS-1:0]     match_o,
    output logic [WAYS-1:0]     valid_o,
    output logic                hit_o,
    output logic [WAY_BITS-1:0] hit_way_o
);
    logic [TAG_W-1:0] tag_q [WAYS];
    logic [WAYS-1:0]  vld_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                vld_q[w] <= 1'b0;
            end else if (set_en && set_way == WAY_BITS'(w)) begin
                vld_q[w] <= 1'b1;
            end else if (inv_en && inv_way == WAY_BITS'(w)) begin
                vld_q[w] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (set_en && set_way == WAY_BITS'(w)) begin
                tag_q[w] <= set_tag;
            end
        end

        assign match_o[w] = vld_q[w] && (tag_q[w] == lk_tag);
    end

    assign valid_o = vld_q;
    assign hit_o   = |match_o;

    always_comb begin
        hit_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_o[w]) begin
                hit_way_o = WAY_BITS'(w);
            end
        end
    end

endmodule

// File: rtl/cc_line_store.sv
module cc_line_store #(
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/cam_line_cache.sv
module cam_line_cache
    import cc_cache_pkg::*;
#(
    parameter int unsigned ADDR_W    = CC_ADDR_W,
    parameter int unsigned WORD_W    = CC_WORD_W,
    parameter int unsigned BEAT_BITS = CC_BEAT_BITS,
    parameter int unsigned BANK_BITS = CC_BANK_BITS,
    parameter int unsigned WAY_BITS  = CC_WAY_BITS,
    parameter logic [WAY_BITS-1:0] VICTIM_TAPS = CC_VICTIM_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_data
);
    localparam int unsigned BYTE_W = $clog2(WORD_W / 8);
    localparam int unsigned OFF_W  = BYTE_W + BEAT_BITS;
    localparam int unsigned LINE_W = ADDR_W - OFF_W;
    localparam int unsigned TAG_W  = LINE_W - BANK_BITS;
    localparam int unsigned BANKS  = 1 << BANK_BITS;
    localparam int unsigned WAYS   = 1 << WAY_BITS;
    localparam int unsigned IDX_W  = BANK_BITS + WAY_BITS + BEAT_BITS;

    // Request address fields.
    logic [BANK_BITS-1:0] lk_bank;
    logic [TAG_W-1:0]     lk_tag;
    logic [BEAT_BITS-1:0] lk_beat;
    logic                 unused_byte_bits;

    assign lk_bank          = req_addr[OFF_W +: BANK_BITS];
    assign lk_tag           = req_addr[ADDR_W-1 -: TAG_W];
    assign lk_beat          = req_addr[BYTE_W +: BEAT_BITS];
    assign unused_byte_bits = ^req_addr[BYTE_W-1:0];

    // Controller state.
    cc_phase_e            phase_q;
    logic [LINE_W-1:0]    fill_line_q;
    logic [WAY_BITS-1:0]  fill_way_q;
    logic [BEAT_BITS-1:0] fill_beat_q;
    logic [BEAT_BITS-1:0] want_beat_q;
    logic [WORD_W-1:0]    rsp_data_q;

    logic [BANK_BITS-1:0] fill_bank;
    logic [TAG_W-1:0]     fill_tag;
    assign fill_bank = fill_line_q[BANK_BITS-1:0];
    assign fill_tag  = fill_line_q[LINE_W-1 -: TAG_W];

    // Victim source.
    logic [WAY_BITS-1:0] victim_way;

    cc_victim_gen #(
        .W    (WAY_BITS),
        .TAPS (VICTIM_TAPS)
    ) victim_i (
        .clk   (clk),
        .rst   (rst),
        .way_o (victim_way)
    );

    // Tag banks.
    logic [BANKS-1:0]         bank_hit;
    logic [WAY_BITS-1:0]      bank_hit_way [BANKS];
    logic [BANKS*WAYS-1:0]    match_all;
    logic [BANKS*WAYS-1:0]    valid_all;

    logic          accept;
    logic          sel_hit;
    cc_decision_t  dec;
    logic          word_taken;
    logic          last_beat;

    assign accept     = (phase_q == CC_IDLE) && req_valid;
    assign sel_hit    = bank_hit[lk_bank] && !flush;
    assign dec        = cc_decide(req_write, sel_hit);
    assign word_taken = (phase_q == CC_FILL) && mem_ack;
    assign last_beat  = (fill_beat_q == {BEAT_BITS{1'b1}});

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic                bank_sel;
        logic                inv_en;
        logic [WAY_BITS-1:0] inv_way;
        logic                set_en;

        assign bank_sel = accept && (lk_bank == BANK_BITS'(b));
        // A write hit drops the matching entry; a read miss drops the
        // victim so a partly written line can never be matched.
        assign inv_en   = bank_sel && (dec.write_hit || dec.read_miss);
        assign inv_way  = dec.write_hit ? bank_hit_way[b] : victim_way;
        assign set_en   = word_taken && last_beat && (fill_bank == BANK_BITS'(b));

        cc_tag_bank #(
            .WAY_BITS (WAY_BITS),
            .TAG_W    (TAG_W)
        ) bank_i (
            .clk       (clk),
            .rst       (rst),
            .clr_all   (flush),
            .lk_tag    (lk_tag),
            .inv_en    (inv_en),
            .inv_way   (inv_way),
            .set_en    (set_en),
            .set_way   (fill_way_q),
            .set_tag   (fill_tag),
            .match_o   (match_all[b*WAYS +: WAYS]),
            .valid_o   (valid_all[b*WAYS +: WAYS]),
            .hit_o     (bank_hit[b]),
            .hit_way_o (bank_hit_way[b])
        );
    end

    // Line data.
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] rd_word;

    assign rd_idx = {lk_bank, bank_hit_way[lk_bank], lk_beat};
    assign wr_idx = {fill_bank, fill_way_q, fill_beat_q};

    cc_line_store #(
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) store_i (
        .clk   (clk),
        .we    (word_taken),
        .widx  (wr_idx),
        .wdata (mem_data),
        .ridx  (rd_idx),
        .rdata (rd_word)
    );

    // Sequencing.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= CC_IDLE;
            fill_line_q <= '0;
            fill_way_q  <= '0;
            fill_beat_q <= '0;
            want_beat_q <= '0;
            rsp_data_q  <= '0;
        end else begin
            unique case (phase_q)
                CC_IDLE: begin
                    if (accept) begin
                        if (dec.read_miss) begin
                            phase_q     <= CC_FILL;
                            fill_line_q <= req_addr[ADDR_W-1:OFF_W];
                            fill_way_q  <= victim_way;
                            fill_beat_q <= '0;
                            want_beat_q <= lk_beat;
                        end else begin
                            phase_q    <= CC_DONE;
                            rsp_data_q <= dec.read_hit ? rd_word : '0;
                        end
                    end
                end
                CC_FILL: begin
                    if (mem_ack) begin
                        fill_beat_q <= fill_beat_q + 1'b1;
                        if (fill_beat_q == want_beat_q) begin
                            rsp_data_q <= mem_data;
                        end
                        if (last_beat) begin
                            phase_q <= CC_DONE;
                        end
                    end
                end
                CC_DONE: begin
                    phase_q <= CC_IDLE;
                end
                default: begin
                    phase_q <= CC_IDLE;
                end
            endcase
        end
    end

    assign rsp_ready = (phase_q == CC_DONE);
    assign rsp_data  = rsp_data_q;
    assign mem_req   = (phase_q == CC_FILL);
    assign mem_addr  = {fill_line_q, fill_beat_q, {BYTE_W{1'b0}}};

endmodule

// File: rtl/cc_cache_checker.sv
module cc_cache_checker #(
    parameter int unsigned BANKS  = 4,
    parameter int unsigned WAYS   = 64,
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned BYTE_W = 2,
    parameter int unsigned OFF_W  = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  flush,
    input logic                  rsp_ready,
    input logic                  mem_req,
    input logic                  mem_ack,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [BANKS*WAYS-1:0] match_all,
    input logic [BANKS*WAYS-1:0] valid_all
);
    // R9: at most one entry of a bank matches any tag
    for (genvar b = 0; b < BANKS; b++) begin : g_uniq
        assert_unique_tag_R9: assert property (@(posedge clk) disable iff (rst)
            $onehot0(match_all[b*WAYS +: WAYS]));
    end

    // R7: a flush empties all banks by the next cycle
    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_all == '0));

    // R10: response strobe lasts one cycle
    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |=> !rsp_ready);

    // R3: an unanswered fill request holds its address
    assert_fill_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3: fill words advance by one word until the line end
    assert_fill_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !(&mem_addr[OFF_W-1:BYTE_W]))
        |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1 << BYTE_W)));

    // R4: the response follows the last fill word
    assert_last_beat_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && (&mem_addr[OFF_W-1:BYTE_W])) |=> rsp_ready);

    // R2: no memory traffic while responding
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && rsp_ready));

    // R11: reset leaves the outputs idle
    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!rsp_ready && !mem_req));

endmodule

bind cam_line_cache cc_cache_checker #(
    .BANKS  (BANKS),
    .WAYS   (WAYS),
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .OFF_W  (OFF_W)
) checker_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .rsp_ready (rsp_ready),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .match_all (match_all),
    .valid_all (valid_all)
);

// File: tb/cam_line_cache_tb_top.sv
module cam_line_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic        rsp_ready;
    logic [31:0] rsp_data;
    logic        mem_req;
    logic [25:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_data = '0;

    int n_checks = 0;
    int n_fails  = 0;
    int mon_err  = 0;
    bit miss_allowed = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cam_line_cache dut_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_data  (mem_data)
    );

    // Memory contents are a fixed function of the word address.
    function automatic logic [31:0] mem_word(input logic [25:0] a);
        logic [31:0] w;
        w = {6'd0, a[25:2], 2'b00};
        return (w * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Every-cycle model check: memory traffic only when a miss is allowed,
    // and never together with a response.
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && !miss_allowed) mon_err++;
            if (mem_req && rsp_ready)     mon_err++;
        end
    end

    // exp: 0 must miss, 1 must hit, 2 either
    task automatic do_read(input logic [25:0] a, input int exp, input bit stall,
                           input bit with_flush, input string rq,
                           output bit missed);
        int          cyc;
        int          words;
        int          stalls;
        bit          addr_ok;
        bit          ph;
        logic [25:0] base;
        logic [31:0] got;
        base = {a[25:4], 4'b0000};
        cyc = 0; words = 0; stalls = 0; addr_ok = 1'b1; ph = 1'b0; got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; flush = with_flush;
        miss_allowed = (exp != 1);
        forever begin
            @(negedge clk);
            flush = 1'b0;
            cyc++;
            if (rsp_ready) begin
                got = rsp_data;
                mem_ack = 1'b0;
                break;
            end
            if (mem_req) begin
                if (stall && !ph) begin
                    mem_ack = 1'b0; ph = 1'b1; stalls++;
                end else begin
                    if (mem_addr != base + 26'(4 * words)) addr_ok = 1'b0;
                    mem_ack = 1'b1;
                    mem_data = mem_word(mem_addr);
                    words++;
                    ph = 1'b0;
                end
            end else begin
                mem_ack = 1'b0;
            end
            if (cyc > 64) break;
        end
        req_valid = 1'b0;
        miss_allowed = 1'b0;
        missed = (words != 0);
        chk(rsp_ready && got == mem_word(a), rq, "read data", got, mem_word(a));
        if (exp == 0) chk(missed, rq, "expected miss", words, 4);
        if (exp == 1) chk(!missed && cyc == 1, rq, "expected hit latency", cyc, 1);
        if (missed) begin
            chk(words == 4 && addr_ok, rq, "fill word count/order", words, 4);
            chk(cyc == 5 + stalls, rq, "miss response cycle", cyc, 5 + stalls);
        end
    endtask

    task automatic do_write(input logic [25:0] a, input string rq);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a;
        @(negedge clk);
        chk(rsp_ready && !mem_req, rq, "write ack in one cycle",
            {rsp_ready, mem_req}, 2'b10);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic final_report();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        final_report();
    end

    initial begin
        bit          m;
        int          misses;
        logic [25:0] a_addr;
        logic [25:0] b_addr;

        a_addr = 26'h012_3458;   // bank 1
        b_addr = 26'h00A_BC00;   // bank 0

        repeat (4) @(negedge clk);
        chk(!rsp_ready && !mem_req, "R11", "idle outputs in reset",
            {rsp_ready, mem_req}, 0);
        rst = 1'b0;

        // R11: cache starts empty; R3/R4 first fill
        do_read(a_addr, 0, 1'b0, 1'b0, "R11", m);
        // R2, R5: re-read and neighbouring word hit
        do_read(a_addr, 1, 1'b0, 1'b0, "R5", m);
        do_read(a_addr + 26'h4, 1, 1'b0, 1'b0, "R2", m);

        // R1: same tag in all four banks held independently
        do_read(b_addr,          0, 1'b1, 1'b0, "R3", m);
        do_read(b_addr + 26'h10, 0, 1'b0, 1'b0, "R1", m);
        do_read(b_addr + 26'h20, 0, 1'b1, 1'b0, "R4", m);
        do_read(b_addr + 26'h30, 0, 1'b0, 1'b0, "R1", m);
        for (int i = 0; i < 4; i++)
            do_read(b_addr + 26'(16 * i) + 26'hC, 1, 1'b0, 1'b0, "R1", m);
        // R1: different tag in the same bank does not alias
        do_read(b_addr + 26'h40, 0, 1'b0, 1'b0, "R1", m);
        do_read(b_addr, 1, 1'b0, 1'b0, "R1", m);

        // R6: write hit invalidates, write miss has no effect
        do_write(a_addr, "R6");
        do_read(a_addr, 0, 1'b0, 1'b0, "R6", m);
        do_write(26'h3F0_0000, "R10");
        do_read(a_addr, 1, 1'b0, 1'b0, "R6", m);
        do_read(b_addr, 1, 1'b0, 1'b0, "R6", m);

        // R7: flush in the request cycle forces a miss; all banks cleared
        do_read(b_addr, 0, 1'b0, 1'b1, "R7", m);
        do_read(b_addr + 26'h10, 0, 1'b0, 1'b0, "R7", m);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        do_read(b_addr, 0, 1'b0, 1'b0, "R7", m);
        do_read(b_addr + 26'h10, 0, 1'b0, 1'b0, "R7", m);

        // R9: after each fill a write leaves no surviving copy
        for (int j = 0; j < 4; j++) begin
            logic [25:0] d;
            d = 26'((32'h200 + j) << 6) | 26'(j << 4);
            do_read(d, 0, 1'b0, 1'b0, "R9", m);
            do_write(d + 26'h8, "R9");
            do_read(d, 0, 1'b0, 1'b0, "R9", m);
            do_read(d, 1, 1'b0, 1'b0, "R9", m);
        end

        // R8: 65 distinct lines into bank 0 must evict at least one
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int i = 0; i <= 64; i++)
            do_read(26'((32'h100 + i) << 6), 0, 1'b0, 1'b0, "R8", m);
        do_read(26'((32'h100 + 64) << 6), 1, 1'b0, 1'b0, "R8", m);
        misses = 0;
        for (int i = 0; i < 64; i++) begin
            do_read(26'((32'h100 + i) << 6), 2, 1'b0, 1'b0, "R8", m);
            if (m) misses++;
        end
        chk(misses >= 1, "R8", "evictions after overfilling a bank", misses, 1);

        chk(mon_err == 0, "R2", "per-cycle memory traffic model", mon_err, 0);
        final_report();
    end

endmodule